// File: doc/BRIEF.md
# USB Bridge Stream-In Writer

This block lives in the FPGA and feeds a continuous stream of words into the slave FIFO of an external USB bridge device. The bridge forwards that data to the host. The FPGA supplies the interface clock. Before any data moves, the block announces that the clock is present. It does this by driving a ready line low for a fixed number of cycles and then high again. It then waits until the bridge raises its acknowledge line, which confirms that the bridge now runs from the external clock.

Once the acknowledge is seen, the block takes words from a valid/ready source. It writes each one to the bridge with an active-low write strobe. The endpoint address stays fixed and the output enable stays inactive for the whole session. A low full flag stops the writes at once. A packet-end request commits a short packet. It produces a single-cycle strobe that never shares a cycle with a write and never occurs while the FIFO is full.

The controller has five states. BOOT is the reset state. ANNOUNCE holds the ready line low. IDLE is connected but not writing. WRITE streams words. COMMIT issues the packet-end strobe. The transitions are as follows:
- BOOT always moves to ANNOUNCE.
- ANNOUNCE moves to IDLE once its low phase has run its length.
- IDLE and WRITE move to COMMIT when a packet end is pending, the flag is not full and the acknowledge is seen.
- IDLE and WRITE move to WRITE when the flag is not full and the acknowledge is seen, and otherwise to IDLE.
- COMMIT always returns to IDLE.

Top module: `usb_stream_writer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, wr_n, pktend_n, oe_n and clk_rdy are high and src_ready is low.
- R2: After reset, clk_rdy goes low for exactly PULSE_LOW_CYC cycles (4 by default). It then returns high and stays high.
- R3: bridge_ack passes through a two-stage synchroniser. If bridge_ack is first high in cycle a and full_n stays high, src_ready is high from cycle a+3 and low in cycle a+2. If bridge_ack falls in cycle d, src_ready is still high in cycle d+2 and low from cycle d+3.
- R4: wr_n is low exactly in cycles where the block is in WRITE, full_n is high and src_valid is high. In such a cycle fifo_data carries src_data. Every accepted word reaches the bus once and in order.
- R5: In any cycle with full_n low, wr_n is high and src_ready is low. When full_n has been high for two consecutive cycles and no commit intervenes, a cycle with src_valid high writes.
- R6: oe_n stays high and fifo_addr stays at EP_ADDR (2'b10 by default) in every cycle.
- R7: A packet-end request in cycle t, with full_n high, drives pktend_n low in cycle t+2 only. In that cycle wr_n is high and src_ready is low.
- R8: A request made while full_n is low is held. pktend_n stays high while full_n is low. It goes low in the cycle after the first cycle in which full_n is high again.
- R9: Requests in consecutive cycles before the commit produce one strobe. pktend_n is low for exactly one cycle in a row.
- R10: With DATA_W = 8, fifo_data[15:8] is zero and fifo_data[7:0] carries src_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, also supplied to the bridge |
| rst_n | input | 1 | Active-low synchronous reset |
| full_n | input | 1 | Bridge FIFO flag, low when full |
| bridge_ack | input | 1 | Bridge confirms it runs on the external clock (asynchronous) |
| src_valid | input | 1 | Source word available |
| src_data | input | DATA_W | Source word |
| src_ready | output | 1 | Word consumed this cycle if src_valid is high |
| pkt_end_req | input | 1 | Request to commit a short packet |
| wr_n | output | 1 | Active-low FIFO write strobe |
| oe_n | output | 1 | Active-low FIFO output enable, held inactive |
| fifo_addr | output | 2 | Endpoint select for the stream toward the host |
| fifo_data | output | 16 | FIFO data bus |
| pktend_n | output | 1 | Active-low packet-end strobe |
| clk_rdy | output | 1 | Ready line announcing that the interface clock is present |

## Verification
The assertions assume that the full flag changes only between clock edges and is stable around each rising edge. They also assume the bridge never raises its acknowledge before the announce pulse it answers.

The stimulus keeps to these assumptions. It changes every input on the falling edge. It raises bridge_ack only after clk_rdy has returned high. It sweeps repeating full-flag and valid masks, whose expected write cycles follow from the flag value in the current and previous cycle.

// File: rtl/usw_pkg.sv
package usw_pkg;

    typedef enum logic [2:0] {
        ST_BOOT     = 3'd0,
        ST_ANNOUNCE = 3'd1,
        ST_IDLE     = 3'd2,
        ST_WRITE    = 3'd3,
        ST_COMMIT   = 3'd4
    } usw_state_e;

    localparam int USW_BUS_W = 16;

endpackage

// File: rtl/usw_startup.sv
module usw_startup #(
    parameter int PULSE_LOW_CYC = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic announce_i,
    input  logic ack_async_i,
    output logic pulse_done_o,
    output logic ack_sync_o
);

    localparam int CW = $clog2(PULSE_LOW_CYC + 1);

    logic [CW-1:0]          low_cnt;
    logic [SYNC_STAGES-1:0] ack_sr;

    // Counts cycles spent with the ready line driven low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (announce_i) begin
            low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    assign pulse_done_o = announce_i && (low_cnt == CW'(PULSE_LOW_CYC - 1));

    // Multi-stage synchroniser for the bridge acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_sr <= '0;
        end else begin
            ack_sr <= {ack_sr[SYNC_STAGES-2:0], ack_async_i};
        end
    end

    assign ack_sync_o = ack_sr[SYNC_STAGES-1];

endmodule

// File: rtl/usw_pktend.sv
module usw_pktend (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic fire_i,
    output logic pending_o
);

    // A new request re-arms. A fired strobe clears only when no new request arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_o <= 1'b0;
        end else begin
            pending_o <= req_i | (pending_o & ~fire_i);
        end
    end

endmodule

// File: rtl/usw_bus_pack.sv
module usw_bus_pack #(
    parameter int DATA_W = 16,
    parameter int BUS_W  = 16
) (
    input  logic [DATA_W-1:0] din_i,
    output logic [BUS_W-1:0]  bus_o
);

    generate
        if (DATA_W < BUS_W) begin : g_narrow
            assign bus_o = {{(BUS_W - DATA_W){1'b0}}, din_i};
        end else begin : g_full
            assign bus_o = din_i;
        end
    endgenerate

endmodule

// File: rtl/usb_stream_writer.sv
module usb_stream_writer
    import usw_pkg::*;
#(
    parameter int         DATA_W        = 16,
    parameter int         PULSE_LOW_CYC = 4,
    parameter int         SYNC_STAGES   = 2,
    parameter logic [1:0] EP_ADDR       = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_n,
    input  logic              bridge_ack,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    input  logic              pkt_end_req,
    output logic              wr_n,
    output logic              oe_n,
    output logic [1:0]        fifo_addr,
    output logic [15:0]       fifo_data,
    output logic              pktend_n,
    output logic              clk_rdy
);

    usw_state_e state_q, state_d;
    logic       pulse_done;
    logic       ack_sync;
    logic       commit_pending;
    logic       commit_fire;
    logic       link_up;

    usw_startup #(
        .PULSE_LOW_CYC (PULSE_LOW_CYC),
        .SYNC_STAGES   (SYNC_STAGES)
    ) u_startup (
        .clk          (clk),
        .rst_n        (rst_n),
        .announce_i   (state_q == ST_ANNOUNCE),
        .ack_async_i  (bridge_ack),
        .pulse_done_o (pulse_done),
        .ack_sync_o   (ack_sync)
    );

    usw_pktend u_pktend (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (pkt_end_req),
        .fire_i    (commit_fire),
        .pending_o (commit_pending)
    );

    usw_bus_pack #(
        .DATA_W (DATA_W),
        .BUS_W  (USW_BUS_W)
    ) u_pack (
        .din_i (src_data),
        .bus_o (fifo_data)
    );

    assign link_up = ack_sync && full_n;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:     state_d = ST_ANNOUNCE;
            ST_ANNOUNCE: state_d = pulse_done ? ST_IDLE : ST_ANNOUNCE;
            ST_IDLE,
            ST_WRITE: begin
                if (link_up && commit_pending) begin
                    state_d = ST_COMMIT;
                end else if (link_up) begin
                    state_d = ST_WRITE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_COMMIT:   state_d = ST_IDLE;
            default:     state_d = ST_BOOT;
        endcase
    end

    // Bridge-facing outputs.
    always_comb begin
        src_ready   = (state_q == ST_WRITE) && full_n;
        wr_n        = !(src_ready && src_valid);
        commit_fire = (state_q == ST_COMMIT) && full_n;
        pktend_n    = !commit_fire;
        clk_rdy     = (state_q != ST_ANNOUNCE);
        oe_n        = 1'b1;
        fifo_addr   = EP_ADDR;
    end

endmodule

// File: rtl/usw_checker.sv
module usw_checker #(
    parameter int PULSE_LOW_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic full_n,
    input logic bridge_ack,
    input logic src_valid,
    input logic src_ready,
    input logic wr_n,
    input logic pktend_n,
    input logic clk_rdy
);

    localparam int LW = $clog2(PULSE_LOW_CYC + 2);

    logic [1:0]    since_rst;
    logic [LW-1:0] low_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            low_len   <= '0;
        end else begin
            if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
            if (clk_rdy) begin
                low_len <= '0;
            end else if (low_len != {LW{1'b1}}) begin
                low_len <= low_len + 1'b1;
            end
        end
    end

    AST_LOW_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_rdy) |-> (low_len == LW'(PULSE_LOW_CYC))); // R2

    AST_WRITE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && !wr_n) |-> $past(bridge_ack, 3)); // R3

    AST_WRITE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (src_ready && src_valid)); // R4

    AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> (wr_n && !src_ready)); // R5

    AST_PKTEND_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        !pktend_n |-> (wr_n && full_n && !src_ready)); // R7

    AST_PKTEND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pktend_n |=> pktend_n); // R9

endmodule

bind usb_stream_writer usw_checker #(
    .PULSE_LOW_CYC (PULSE_LOW_CYC)
) u_usw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .full_n     (full_n),
    .bridge_ack (bridge_ack),
    .src_valid  (src_valid),
    .src_ready  (src_ready),
    .wr_n       (wr_n),
    .pktend_n   (pktend_n),
    .clk_rdy    (clk_rdy)
);

// File: tb/usb_stream_writer_bench.sv
module usb_stream_writer_bench;

    localparam int LOW_CYC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        full_n = 1'b1;
    logic        bridge_ack = 1'b0;
    logic        src_valid = 1'b0;
    logic [15:0] src_data = '0;
    logic [7:0]  src_data_n8;
    logic        pkt_end_req = 1'b0;

    logic        src_ready, wr_n, oe_n, pktend_n, clk_rdy;
    logic [1:0]  fifo_addr;
    logic [15:0] fifo_data;

    logic        src_ready8, wr_n8, oe_n8, pktend_n8, clk_rdy8;
    logic [1:0]  fifo_addr8;
    logic [15:0] fifo_data8;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [15:0] seq = 16'h0100;
    bit prev_full = 1'b1;

    assign src_data_n8 = src_data[7:0];

    always #2 clk = ~clk;

    usb_stream_writer u_usb_stream_writer (
        .clk         (clk),
        .rst_n       (rst_n),
        .full_n      (full_n),
        .bridge_ack  (bridge_ack),
        .src_valid   (src_valid),
        .src_data    (src_data),
        .src_ready   (src_ready),
        .pkt_end_req (pkt_end_req),
        .wr_n        (wr_n),
        .oe_n        (oe_n),
        .fifo_addr   (fifo_addr),
        .fifo_data   (fifo_data),
        .pktend_n    (pktend_n),
        .clk_rdy     (clk_rdy)
    );

    usb_stream_writer #(.DATA_W(8)) u_narrow (
        .clk         (clk),
        .rst_n       (rst_n),
        .full_n      (full_n),
        .bridge_ack  (bridge_ack),
        .src_valid   (src_valid),
        .src_data    (src_data_n8),
        .src_ready   (src_ready8),
        .pkt_end_req (pkt_end_req),
        .wr_n        (wr_n8),
        .oe_n        (oe_n8),
        .fifo_addr   (fifo_addr8),
        .fifo_data   (fifo_data8),
        .pktend_n    (pktend_n8),
        .clk_rdy     (clk_rdy8)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // One cycle: drive at the falling edge, sample shortly after.
    task automatic step(input bit f, input bit v, input bit rq);
        @(negedge clk);
        full_n = f; src_valid = v; pkt_end_req = rq; src_data = seq;
        #1;
        check(oe_n == 1'b1 && fifo_addr == 2'b10, "R6", {oe_n, fifo_addr}, 3'b110);
        check(fifo_data8 == {8'h00, seq[7:0]}, "R10", fifo_data8, {8'h00, seq[7:0]});
        if (!f) check(wr_n && !src_ready && pktend_n, "R5", {wr_n, src_ready, pktend_n}, 3'b101);
        if (!wr_n) begin
            check(fifo_data == seq, "R4", fifo_data, seq);
            seq = seq + 16'd1;
        end
    endtask

    initial begin
        int lows;
        int pk;
        bit exp_w;
        // R1: reset values
        repeat (3) @(negedge clk);
        check(wr_n && pktend_n && oe_n && clk_rdy && !src_ready, "R1", {wr_n, pktend_n, oe_n, clk_rdy, src_ready}, 5'b11110);
        rst_n = 1'b1;
        #1;
        check(wr_n && pktend_n && clk_rdy && !src_ready, "R1", {wr_n, pktend_n, clk_rdy, src_ready}, 4'b1110);
        // R2: count low cycles of the ready line
        lows = 0;
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 1'b1, 1'b0);
            if (!clk_rdy) lows++;
            check(src_ready == 1'b0 && wr_n, "R3", src_ready, 0);
        end
        check(lows == LOW_CYC, "R2", lows, LOW_CYC);
        check(clk_rdy == 1'b1, "R2", clk_rdy, 1);
        // R3: acknowledge latency
        @(negedge clk); bridge_ack = 1'b1;
        #1; check(src_ready == 1'b0, "R3", src_ready, 0);
        step(1'b1, 1'b0, 1'b0); check(src_ready == 1'b0, "R3", src_ready, 0);
        step(1'b1, 1'b0, 1'b0); check(src_ready == 1'b0, "R3", src_ready, 0);
        step(1'b1, 1'b0, 1'b0); check(src_ready == 1'b1, "R3", src_ready, 1);
        prev_full = 1'b1;
        // R4/R5: sweep repeating full and valid masks
        for (int fm = 0; fm < 16; fm++) begin
            for (int vi = 0; vi < 4; vi++) begin
                logic [3:0] vm;
                vm = (vi == 0) ? 4'hF : (vi == 1) ? 4'h5 : (vi == 2) ? 4'hE : 4'h9;
                for (int c = 0; c < 16; c++) begin
                    bit f, v;
                    f = (fm == 0) ? 1'b1 : fm[c % 4];
                    v = vm[(c + fm) % 4];
                    exp_w = f && prev_full && v;
                    step(f, v, 1'b0);
                    check(wr_n == !exp_w, "R4", wr_n, !exp_w);
                    check(src_ready == (f && prev_full), "R5", src_ready, f && prev_full);
                    prev_full = f;
                end
            end
        end
        repeat (3) step(1'b1, 1'b1, 1'b0);
        // R7: request with room
        step(1'b1, 1'b1, 1'b1);
        check(pktend_n == 1'b1, "R7", pktend_n, 1);
        step(1'b1, 1'b1, 1'b0);
        check(pktend_n == 1'b1, "R7", pktend_n, 1);
        step(1'b1, 1'b1, 1'b0);
        check(!pktend_n && wr_n && !src_ready, "R7", {pktend_n, wr_n, src_ready}, 3'b010);
        step(1'b1, 1'b1, 1'b0);
        check(pktend_n == 1'b1, "R7", pktend_n, 1);
        repeat (3) step(1'b1, 1'b1, 1'b0);
        // R8: request while full is held
        step(1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b1, 1'b0);
            check(pktend_n == 1'b1, "R8", pktend_n, 1);
        end
        step(1'b1, 1'b1, 1'b0);
        check(pktend_n == 1'b1, "R8", pktend_n, 1);
        step(1'b1, 1'b1, 1'b0);
        check(pktend_n == 1'b0, "R8", pktend_n, 0);
        repeat (3) step(1'b1, 1'b1, 1'b0);
        // R9: back-to-back requests coalesce
        pk = 0;
        step(1'b1, 1'b1, 1'b1); if (!pktend_n) pk++;
        step(1'b1, 1'b1, 1'b1); if (!pktend_n) pk++;
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 1'b1, 1'b0);
            if (!pktend_n) pk++;
        end
        check(pk == 1, "R9", pk, 1);
        // R3: acknowledge drop
        @(negedge clk); bridge_ack = 1'b0;
        #1; check(src_ready == 1'b1, "R3", src_ready, 1);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0); check(src_ready == 1'b1, "R3", src_ready, 1);
        step(1'b1, 1'b1, 1'b0); check(src_ready == 1'b0, "R3", src_ready, 0);
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b1, 1'b0);
            check(wr_n == 1'b1, "R3", wr_n, 1);
        end
        finish_run();
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                check(1'b0, "watchdog", cycles, 50000);
                finish_run();
            end
        end
    end

endmodule